// File: doc/BRIEF.md
# Dithered Fractional-N Reference Divider

This block divides a reference clock by a ratio that has an integer part and an optional fraction. A down-counter marks the end of every divide cycle with a one-clock pulse. When the modulator is enabled, a second-order sigma-delta stage adjusts the counter's modulus from one divide cycle to the next. Over many cycles the mean ratio then settles at N + 1/2 + F/(2M). N is the integer part, M is a positive modulus and F is a signed offset with |F| < M. The half-step offset is built in, so F = 0 already gives a ratio halfway between two integers.

A 15-bit pseudorandom sequence dithers the modulator so that its idle patterns break up. The dither runs from reset, and one control input switches it off. A restricted mode is entered when either of two 4-bit selection codes is all ones. In that mode the modulator is held off, and only the ratios 1, 2 and 4 are legal. Settings are sampled only at the divide-cycle boundary. A flag reports a setting that the current mode cannot honour. The divider then falls back to plain division by N.

Top module: `frac_ref_divider`

## Requirements
- R1: With the modulator off, or not usable for the current settings, every interval between output pulses is exactly N clocks for N in 1..63. N = 0 divides by 1.
- R2: With the modulator active, the 2M pulse intervals that follow the first pulse after reset add up to between 2M·N + M + F and 2M·N + M + F + 1 clocks.
- R3: With the modulator active, each single interval lies between N−1 and N+2 clocks.
- R4: With the modulator enabled and |F| >= M, the error flag is 1 and the divider divides by N.
- R5: With the modulator enabled and N < 4, the error flag is 1 and the divider divides by N.
- R6: Dither is on after reset and alters the interval sequence; asserting the dither-disable input gives the undithered sequence, and the sum bound of R2 holds either way.
- R7: Restricted mode is in effect when sel_a == 4'b1111 or sel_b == 4'b1111. The modulator then stays off, the divider divides by N, and the error flag is 1 unless N is 1, 2 or 4.
- R8: A settings change made inside a divide cycle does not alter that cycle's length; it applies from the next cycle.
- R9: While reset is low, div_pulse and cfg_err are 0.
- R10: cfg_err changes only in the clock in which div_pulse is 1, and it reflects the settings in use for the interval that has just started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_ratio | input | INT_W | Integer part N |
| frac_val | input | MOD_W+1 | Signed fractional offset F |
| modulus | input | MOD_W | Modulus M |
| sdm_en | input | 1 | Enable the sigma-delta modulator |
| dither_off | input | 1 | 1 disables the pseudorandom dither |
| sel_a | input | 4 | First selection code |
| sel_b | input | 4 | Second selection code |
| div_pulse | output | 1 | One-clock pulse per divide cycle |
| cfg_err | output | 1 | Settings in use are not legal for the mode |

## Verification
The assertions assume that every setting input is synchronous to clk. They also assume that reset is low at the first clock edge, so that the interval bookkeeping starts from a known pulse. The checker keeps its own copy of the settings the divider sampled at each boundary. Because of that, the stimulus may change settings in mid-cycle, as the R8 test does, without tripping the interval properties. The bench changes inputs only on falling edges and holds reset for several cycles. It keeps M no larger than the modulus width allows, so M + F never falls outside 1..2M−1 while the modulator runs.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic [1:0] {
        MODE_INT      = 2'd0,
        MODE_SDM      = 2'd1,
        MODE_RESTRICT = 2'd2
    } div_mode_e;

    // Ratios accepted while the restricted mode is selected
    function automatic logic restricted_ratio_ok(input logic [7:0] n);
        return (n == 8'd1) || (n == 8'd2) || (n == 8'd4);
    endfunction

    // Smallest integer part the modulator is allowed to work with
    localparam int SDM_MIN_N = 4;

endpackage

// File: rtl/frac_div_cfg_check.sv
module frac_div_cfg_check
    import frac_div_pkg::*;
#(
    parameter int INT_W = 6,
    parameter int MOD_W = 8,
    parameter int SEL_W = 4
) (
    input  logic [INT_W-1:0]        n_in,
    input  logic signed [MOD_W:0]   f_in,
    input  logic [MOD_W-1:0]        m_in,
    input  logic                    sdm_req,
    input  logic [SEL_W-1:0]        code_a,
    input  logic [SEL_W-1:0]        code_b,
    output div_mode_e               mode,
    output logic                    bad_cfg
);
    logic [MOD_W:0] abs_f;
    logic           frac_bad;
    logic           n_small;
    logic           restricted;
    logic [7:0]     n_wide;

    always_comb begin
        abs_f      = f_in[MOD_W] ? (~f_in + 1'b1) : f_in;
        frac_bad   = abs_f >= {1'b0, m_in};
        n_small    = n_in < INT_W'(SDM_MIN_N);
        restricted = (&code_a) | (&code_b);
        n_wide     = 8'(n_in);

        if (restricted) begin
            mode    = MODE_RESTRICT;
            bad_cfg = !restricted_ratio_ok(n_wide);
        end else if (sdm_req && !frac_bad && !n_small) begin
            mode    = MODE_SDM;
            bad_cfg = 1'b0;
        end else begin
            mode    = MODE_INT;
            bad_cfg = (n_in == '0) || (sdm_req && (frac_bad || n_small));
        end
    end
endmodule

// File: rtl/frac_div_prbs.sv
module frac_div_prbs #(
    parameter int PRBS_W = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic rnd_bit
);
    localparam logic [PRBS_W-1:0] SEED = PRBS_W'(1);

    typedef struct packed {
        logic [PRBS_W-1:0] sr;
    } prbs_state_t;

    prbs_state_t st_d, st_q;
    logic [PRBS_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.sr[PRBS_W-2:0], st_q.sr[TAP_HI] ^ st_q.sr[TAP_LO]};
        if (advance) begin
            // lock-up guard: the all-zero word would never leave itself
            st_d.sr = (shifted == '0) ? SEED : shifted;
        end
        rnd_bit = st_q.sr[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sr <= SEED;
        else        st_q    <= st_d;
    end
endmodule

// File: rtl/frac_div_mash.sv
module frac_div_mash #(
    parameter int MOD_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  clear,
    input  logic signed [MOD_W:0] f_in,
    input  logic [MOD_W-1:0]      m_in,
    input  logic                  dith,
    output logic signed [2:0]     corr
);
    localparam int ACC_W = MOD_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc1;
        logic [ACC_W-1:0] acc2;
        logic             c2;
    } mash_state_t;

    mash_state_t st_d, st_q;

    logic [ACC_W-1:0]      two_m;
    logic signed [ACC_W:0] inc_s;
    logic [ACC_W-1:0]      inc;
    logic [ACC_W-1:0]      s1, s2, a1n, a2n;
    logic                  c1, c2;

    always_comb begin
        two_m = {1'b0, m_in, 1'b0};
        // one-half offset: stage one adds M + F against a 2M wrap
        inc_s = $signed({3'b000, m_in}) + $signed({{2{f_in[MOD_W]}}, f_in});
        inc   = inc_s[ACC_W-1:0];

        s1  = st_q.acc1 + inc;
        c1  = s1 >= two_m;
        a1n = c1 ? (s1 - two_m) : s1;

        // dither enters stage two, whose carry is differenced away
        s2  = st_q.acc2 + a1n + {{(ACC_W-1){1'b0}}, dith};
        c2  = s2 >= two_m;
        a2n = c2 ? (s2 - two_m) : s2;

        corr = $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, st_q.c2});

        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (step) begin
            st_d.acc1 = a1n;
            st_d.acc2 = a2n;
            st_d.c2   = c2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/frac_div_counter.sv
module frac_div_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load,
    output logic             at_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        at_end = st_q.cnt == '0;
        st_d   = st_q;
        if (at_end) st_d.cnt = load - 1'b1;
        else        st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/frac_ref_divider.sv
module frac_ref_divider
    import frac_div_pkg::*;
#(
    parameter int INT_W  = 6,
    parameter int MOD_W  = 8,
    parameter int SEL_W  = 4,
    parameter int PRBS_W = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INT_W-1:0]      int_ratio,
    input  logic signed [MOD_W:0] frac_val,
    input  logic [MOD_W-1:0]      modulus,
    input  logic                  sdm_en,
    input  logic                  dither_off,
    input  logic [SEL_W-1:0]      sel_a,
    input  logic [SEL_W-1:0]      sel_b,
    output logic                  div_pulse,
    output logic                  cfg_err
);
    localparam int CNT_W = INT_W + 1;

    typedef struct packed {
        logic pulse;
        logic err;
    } top_state_t;

    top_state_t st_d, st_q;

    div_mode_e             mode;
    logic                  bad_cfg;
    logic                  boundary;
    logic                  sdm_step;
    logic                  sdm_clear;
    logic                  prbs_adv;
    logic                  rnd_bit;
    logic                  dith;
    logic signed [2:0]     corr;
    logic signed [CNT_W:0] sdm_sum;
    logic [CNT_W-1:0]      load;

    frac_div_cfg_check #(.INT_W(INT_W), .MOD_W(MOD_W), .SEL_W(SEL_W)) u_cfg (
        .n_in    (int_ratio),
        .f_in    (frac_val),
        .m_in    (modulus),
        .sdm_req (sdm_en),
        .code_a  (sel_a),
        .code_b  (sel_b),
        .mode    (mode),
        .bad_cfg (bad_cfg)
    );

    frac_div_prbs #(.PRBS_W(PRBS_W), .TAP_HI(PRBS_W-1), .TAP_LO(PRBS_W-2)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (prbs_adv),
        .rnd_bit (rnd_bit)
    );

    frac_div_mash #(.MOD_W(MOD_W)) u_mash (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sdm_step),
        .clear (sdm_clear),
        .f_in  (frac_val),
        .m_in  (modulus),
        .dith  (dith),
        .corr  (corr)
    );

    frac_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .at_end (boundary)
    );

    always_comb begin
        sdm_step  = boundary && (mode == MODE_SDM);
        sdm_clear = boundary && (mode != MODE_SDM);
        prbs_adv  = sdm_step && !dither_off;
        dith      = !dither_off && rnd_bit;

        sdm_sum = $signed({2'b00, int_ratio}) + CNT_W'(corr);
        if (mode == MODE_SDM)
            load = sdm_sum[CNT_W-1:0];
        else if (int_ratio == '0)
            load = CNT_W'(1);
        else
            load = {1'b0, int_ratio};

        st_d       = st_q;
        st_d.pulse = boundary;
        if (boundary) st_d.err = bad_cfg;

        div_pulse = st_q.pulse;
        cfg_err   = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/frac_ref_divider_chk.sv
module frac_ref_divider_chk #(
    parameter int INT_W = 6,
    parameter int MOD_W = 8,
    parameter int SEL_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [INT_W-1:0]      int_ratio,
    input logic signed [MOD_W:0] frac_val,
    input logic [MOD_W-1:0]      modulus,
    input logic                  sdm_en,
    input logic [SEL_W-1:0]      sel_a,
    input logic [SEL_W-1:0]      sel_b,
    input logic                  div_pulse,
    input logic                  cfg_err
);
    localparam int GAP_W = INT_W + 3;

    logic [INT_W-1:0]      last_n, ref_n;
    logic signed [MOD_W:0] last_f, ref_f;
    logic [MOD_W-1:0]      last_m, ref_m;
    logic                  last_sdm, ref_sdm;
    logic                  last_rs, ref_rs;
    logic                  seen_q;
    logic [GAP_W-1:0]      gap_q;

    function automatic logic err_model(input logic [INT_W-1:0] n, input logic signed [MOD_W:0] f,
                                       input logic [MOD_W-1:0] m, input logic sdm, input logic rs);
        logic [MOD_W+1:0] af;
        af = (f < 0) ? (MOD_W+2)'(-f) : (MOD_W+2)'(f);
        if (rs) return !((n == 1) || (n == 2) || (n == 4));
        return (n == 0) || (sdm && ((af >= (MOD_W+2)'(m)) || (n < 4)));
    endfunction

    logic ref_active;
    logic [GAP_W-1:0] ref_eff;
    always_comb begin
        ref_active = ref_sdm && !ref_rs && !err_model(ref_n, ref_f, ref_m, ref_sdm, ref_rs);
        ref_eff    = (ref_n == 0) ? GAP_W'(1) : GAP_W'(ref_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_n <= '0; last_f <= '0; last_m <= '0; last_sdm <= 1'b0; last_rs <= 1'b0;
            ref_n  <= '0; ref_f  <= '0; ref_m  <= '0; ref_sdm  <= 1'b0; ref_rs  <= 1'b0;
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            last_n   <= int_ratio;
            last_f   <= frac_val;
            last_m   <= modulus;
            last_sdm <= sdm_en;
            last_rs  <= (&sel_a) | (&sel_b);
            if (div_pulse) begin
                ref_n   <= last_n;
                ref_f   <= last_f;
                ref_m   <= last_m;
                ref_sdm <= last_sdm;
                ref_rs  <= last_rs;
                seen_q  <= 1'b1;
                gap_q   <= GAP_W'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!div_pulse && !cfg_err));

    // R10
    err_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_err) |-> div_pulse);

    // R4 R5 R7
    err_matches_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (cfg_err == err_model(last_n, last_f, last_m, last_sdm, last_rs)));

    // R1
    int_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && seen_q && !ref_active) |-> (gap_q == ref_eff));

    // R3
    sdm_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && seen_q && ref_active) |->
        ((gap_q + 1'b1 >= GAP_W'(ref_n)) && (gap_q <= GAP_W'(ref_n) + GAP_W'(2))));
endmodule

bind frac_ref_divider frac_ref_divider_chk #(.INT_W(INT_W), .MOD_W(MOD_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_ratio (int_ratio),
    .frac_val  (frac_val),
    .modulus   (modulus),
    .sdm_en    (sdm_en),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/frac_ref_divider_bench.sv
module frac_ref_divider_bench;
    localparam int INT_W = 6;
    localparam int MOD_W = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [INT_W-1:0]      int_ratio = 6'd10;
    logic signed [MOD_W:0] frac_val = '0;
    logic [MOD_W-1:0]      modulus = 8'd8;
    logic                  sdm_en = 1'b0;
    logic                  dither_off = 1'b0;
    logic [3:0]            sel_a = 4'd0;
    logic [3:0]            sel_b = 4'd0;
    logic                  div_pulse, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    frac_ref_divider u_frac_ref_divider (
        .clk(clk), .rst_n(rst_n), .int_ratio(int_ratio), .frac_val(frac_val),
        .modulus(modulus), .sdm_en(sdm_en), .dither_off(dither_off),
        .sel_a(sel_a), .sel_b(sel_b), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // clocks until the next falling edge that shows a pulse
    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!div_pulse && len < 300);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        int       n;
        bit       sdm;
        bit [3:0] sa;
        bit [3:0] sb;
        int       per;
        bit       err;
    } vec_t;

    localparam vec_t VECS[10] = '{
        '{1,  1'b0, 4'h0, 4'h0, 1,  1'b0},   // R1 smallest
        '{2,  1'b0, 4'h0, 4'h0, 2,  1'b0},   // R1
        '{7,  1'b0, 4'h0, 4'h0, 7,  1'b0},   // R1
        '{63, 1'b0, 4'h0, 4'h0, 63, 1'b0},   // R1 largest
        '{0,  1'b0, 4'h0, 4'h0, 1,  1'b1},   // R1 zero divides by one
        '{4,  1'b1, 4'hF, 4'h0, 4,  1'b0},   // R7 modulator forced off
        '{3,  1'b1, 4'h0, 4'hF, 3,  1'b1},   // R7 illegal restricted ratio
        '{2,  1'b0, 4'hF, 4'hF, 2,  1'b0},   // R7
        '{3,  1'b1, 4'h0, 4'h0, 3,  1'b1},   // R5 N below four
        '{9,  1'b0, 4'h7, 4'hE, 9,  1'b0}    // R7 codes not all ones
    };

    int per_on[64];
    int per_off[64];

    task automatic run_sdm(input int n, input int f, input int m, input bit doff,
                           output int per[64]);
        int len, sum, base;
        int_ratio = INT_W'(n); frac_val = (MOD_W+1)'(f); modulus = MOD_W'(m);
        sdm_en = 1'b1; dither_off = doff; sel_a = 4'h0; sel_b = 4'h0;
        do_reset();
        measure(len);                      // first pulse after reset
        sum = 0;
        for (int k = 0; k < 2*m; k++) begin
            measure(len);
            per[k] = len;
            sum += len;
            check(len >= n-1 && len <= n+2, "R3 interval bound", len, n);
        end
        base = 2*m*n + m + f;
        check(sum >= base && sum <= base+1,
              doff ? "R2 average ratio" : "R2 R6 average ratio with dither", sum, base);
    endtask

    initial begin
        int len;
        bit differ;

        // R9 reset state
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R9 pulse low in reset", div_pulse, 0);
        check(cfg_err == 1'b0, "R9 error low in reset", cfg_err, 0);
        rst_n = 1'b1;
        measure(len);

        // table walk
        for (int i = 0; i < 10; i++) begin
            int_ratio = INT_W'(VECS[i].n); sdm_en = VECS[i].sdm;
            sel_a = VECS[i].sa; sel_b = VECS[i].sb;
            frac_val = '0; modulus = 8'd8;
            measure(len);
            measure(len);
            check(len == VECS[i].per, "R1 R5 R7 interval", len, VECS[i].per);
            check(cfg_err == VECS[i].err, "R1 R5 R7 error flag", cfg_err, VECS[i].err);
        end

        // R2 R3 R6 modulator runs
        run_sdm(10, 3, 8, 1'b0, per_on);
        run_sdm(10, 3, 8, 1'b1, per_off);
        differ = 1'b0;
        for (int k = 0; k < 16; k++) if (per_on[k] != per_off[k]) differ = 1'b1;
        check(differ, "R6 dither alters sequence", differ, 1);
        run_sdm(4, -5, 8, 1'b0, per_on);
        run_sdm(20, 0, 5, 1'b0, per_on);
        run_sdm(6, 7, 8, 1'b1, per_off);

        // R4 fraction out of range
        sdm_en = 1'b1; int_ratio = 6'd10; modulus = 8'd8; frac_val = 9'sd8; dither_off = 1'b0;
        measure(len); measure(len); measure(len);
        check(len == 10, "R4 falls back to N", len, 10);
        check(cfg_err == 1'b1, "R4 error flag", cfg_err, 1);
        frac_val = -9'sd8;
        measure(len); measure(len);
        check(len == 10 && cfg_err, "R4 negative F out of range", len, 10);

        // R8 mid-cycle change
        sdm_en = 1'b0; frac_val = '0; int_ratio = 6'd10;
        measure(len); measure(len);
        repeat (3) @(negedge clk);
        int_ratio = 6'd5;
        measure(len);
        check(len == 7, "R8 current cycle keeps old length", len + 3, 10);
        measure(len);
        check(len == 5, "R8 new length next cycle", len, 5);

        // R10 error follows boundary only
        int_ratio = 6'd10;
        measure(len); measure(len);
        repeat (2) @(negedge clk);
        int_ratio = 6'd0;
        @(negedge clk);
        check(cfg_err == 1'b0, "R10 error held inside cycle", cfg_err, 0);
        measure(len);
        check(cfg_err == 1'b1, "R10 error updates at pulse", cfg_err, 1);

        finish_run();
    end
endmodule